// File: doc/BRIEF.md
# Software Write-Protect Sequence Decoder

This block sits in front of the page write controller of a byte-wide non-volatile memory. It watches every byte write that the host issues, as an address and a data byte, and looks for fixed command sequences of three or six writes. Each sequence has its own final byte, and that byte chooses the action: switch write protection on, switch it off, or request a whole-array erase. The enable key is also the way to write while protection is on. After it, the data writes that follow in the same page load are passed through and protection stays on.

The protection state is held in a retained register. Its value at first power-up is "unprotected" and the block reset does not clear it, so the state models a non-volatile latch. The block drives `write_allow` for every incoming write. That signal tells the page write controller whether the write may go to the array. A page load window stays open while writes keep arriving. It closes once `LOAD_TIMEOUT` clock edges in a row have seen no write. A pending action takes effect at the edge that closes the window.

Top module: `swp_seq_decoder`

## Requirements
- R1: At first power-up `prot_on` is 0. After a reset `erase_req` is 0 and no sequence or page load is in progress.
- R2: `rst_n` never changes `prot_on`. The value held before a reset is still shown after it.
- R3: When `prot_on` is 0 and no sequence has fired, `write_allow` equals `wr_valid` in the same cycle. When `prot_on` is 1 and no write grant is open, `write_allow` is 0 for every write.
- R4: The enable key is 8'hAA at 15'h5555, then 8'h55 at 15'h2AAA, then 8'hA0 at 15'h5555. It opens a write grant from the next write until the page load window closes. `prot_on` becomes 1 in the cycle after the edge that closes the window.
- R5: The disable key is 8'hAA at 15'h5555, 8'h55 at 15'h2AAA, 8'h80 at 15'h5555, 8'hAA at 15'h5555, 8'h55 at 15'h2AAA and finally 8'h20 at 15'h5555. It opens a write grant until the window closes. `prot_on` becomes 0 in the cycle after the closing edge.
- R6: The erase key is the disable key with 8'h10 as its sixth byte. When `prot_on` is 0 it produces a one-cycle `erase_req` pulse in the cycle after the window-closing edge. When `prot_on` is 1 the erase key has no effect.
- R7: The enable key given while `prot_on` is 1 lets the rest of that page load through on `write_allow`, and `prot_on` stays 1.
- R8: A write that does not match the next expected step aborts the sequence. That same write is then checked as a possible first step (8'hAA at 15'h5555). A key write is otherwise handled as an ordinary write under R3.
- R9: Only address bits 14:0 are compared with the key addresses. Bits above 14 are ignored.
- R10: The window closes after `LOAD_TIMEOUT` consecutive clock edges with `wr_valid` low. A sequence whose steps are split by a closed window is discarded.
- R11: While a fired action waits for the window to close, further writes do not advance the sequence decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset. It leaves the protection state alone |
| wr_valid | input | 1 | One host byte write in this cycle |
| wr_addr | input | ADDR_W (17) | Byte address of the write |
| wr_data | input | DATA_W (8) | Data byte of the write |
| write_allow | output | 1 | This write may be passed to the page write controller |
| erase_req | output | 1 | One-cycle request to erase the whole array |
| prot_on | output | 1 | Current software protection state (retained) |

## Verification
The bench aims at the enable key given while protection is already on. A design that cleared protection there, or that blocked the page data after the key, would differ from the model right away on `prot_on` or `write_allow`. It also sends an erase key while protected: a design that did not gate erase on the protection state would pulse `erase_req`. Other cases are broken sequences, such as a repeated 8'hAA or wrong data at the third step, key addresses with bit 16 set, and a gap of one full timeout inside a sequence. A design that failed to restart, compared too many address bits, or kept a stale sequence across windows would grant or change protection when it should not. Finally, a reset is applied while protection is on. A design that reset the retained state would show `prot_on` low afterwards.

// File: rtl/swp_pkg.sv
// Shared types and key constants for the write-protect sequence decoder.
// Assumes byte-wide data and a 15-bit key address compare.
package swp_pkg;
    localparam int KEY_W  = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_ENABLE  = 2'd1,
        ACT_DISABLE = 2'd2,
        ACT_ERASE   = 2'd3
    } swp_act_e;

    localparam logic [KEY_W-1:0]  KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0]  KEY_ADDR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KD_FIRST   = 8'hAA;
    localparam logic [DATA_W-1:0] KD_SECOND  = 8'h55;
    localparam logic [DATA_W-1:0] KD_SET     = 8'hA0;
    localparam logic [DATA_W-1:0] KD_LONG    = 8'h80;
    localparam logic [DATA_W-1:0] KD_CLEAR   = 8'h20;
    localparam logic [DATA_W-1:0] KD_WIPE    = 8'h10;
endpackage

// File: rtl/swp_load_timer.sv
// Page load window timer.
// Opens on any write and restarts on every later write. It closes with a
// one-cycle window_end after LOAD_TIMEOUT edges in a row have no write.
// Assumes LOAD_TIMEOUT >= 1.
module swp_load_timer #(
    parameter int LOAD_TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    output logic window_end
);
    localparam int CNT_W = $clog2(LOAD_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_TIMEOUT - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    // Closing edge: window open, no write, idle count at its last value.
    assign window_end = active_q && !wr_valid && (cnt_q == LAST);

    // Track the idle time since the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (wr_valid) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (window_end) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q < CNT_W'(LOAD_TIMEOUT))); // R10
    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        window_end |=> (!active_q || wr_valid || cnt_q == '0)); // R10
endmodule

// File: rtl/swp_key_matcher.sv
// Key sequence decoder.
// Steps through the three-byte and six-byte unlock keys. It gives a one-cycle
// fire together with the action chosen by the final byte. A mismatching write
// restarts the decoder, and that write counts as a first step if it is one.
// The decoder also restarts when the page load window closes. Assumes
// window_end never coincides with a write.
module swp_key_matcher
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [KEY_W-1:0]  key_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold,
    input  logic              window_end,
    output logic              fire,
    output swp_act_e          fire_act
);
    localparam logic [2:0] ST_IDLE = 3'd0;
    localparam logic [2:0] ST_K1   = 3'd1;
    localparam logic [2:0] ST_K2   = 3'd2;
    localparam logic [2:0] ST_K3   = 3'd3;
    localparam logic [2:0] ST_K4   = 3'd4;
    localparam logic [2:0] ST_K5   = 3'd5;

    logic [2:0] step_q, step_d;
    logic       at_a, at_b, is_first, is_second;
    logic [2:0] restart;

    assign at_a      = (key_addr == KEY_ADDR_A);
    assign at_b      = (key_addr == KEY_ADDR_B);
    assign is_first  = at_a && (wr_data == KD_FIRST);
    assign is_second = at_b && (wr_data == KD_SECOND);
    assign restart   = is_first ? ST_K1 : ST_IDLE;

    // Choose the next step and detect a completed key.
    always_comb begin
        step_d   = step_q;
        fire     = 1'b0;
        fire_act = ACT_NONE;
        if (window_end) begin
            step_d = ST_IDLE;
        end else if (wr_valid && !hold) begin
            case (step_q)
                ST_IDLE: step_d = restart;
                ST_K1:   step_d = is_second ? ST_K2 : restart;
                ST_K2: begin
                    if (at_a && wr_data == KD_SET) begin
                        fire     = 1'b1;
                        fire_act = ACT_ENABLE;
                        step_d   = ST_IDLE;
                    end else if (at_a && wr_data == KD_LONG) begin
                        step_d = ST_K3;
                    end else begin
                        step_d = restart;
                    end
                end
                ST_K3:   step_d = is_first ? ST_K4 : ST_IDLE;
                ST_K4:   step_d = is_second ? ST_K5 : restart;
                ST_K5: begin
                    if (at_a && wr_data == KD_CLEAR) begin
                        fire     = 1'b1;
                        fire_act = ACT_DISABLE;
                        step_d   = ST_IDLE;
                    end else if (at_a && wr_data == KD_WIPE) begin
                        fire     = 1'b1;
                        fire_act = ACT_ERASE;
                        step_d   = ST_IDLE;
                    end else begin
                        step_d = restart;
                    end
                end
                default: step_d = ST_IDLE;
            endcase
        end
    end

    // Register the decoder position.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= ST_K5); // R8
    AST_WINDOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        window_end |=> (step_q == ST_IDLE)); // R10
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !window_end) |=> $stable(step_q)); // R11
endmodule

// File: rtl/swp_prot_store.sv
// Protection state, write grant and erase request.
// The protection bit is retained: it starts at 0 at power-up, and rst_n never
// touches it. A fired action is held pending and takes effect at the edge
// that closes the page load window. An erase fired under protection is dropped.
module swp_prot_store
    import swp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_valid,
    input  logic     fire,
    input  swp_act_e fire_act,
    input  logic     window_end,
    output logic     hold,
    output logic     write_allow,
    output logic     erase_req,
    output logic     prot_on
);
    logic     prot_q = 1'b0;
    logic     grant_q;
    logic     erase_q;
    swp_act_e pend_q;

    assign hold        = (pend_q != ACT_NONE);
    assign write_allow = wr_valid && (!prot_q || grant_q);
    assign erase_req   = erase_q;
    assign prot_on     = prot_q;

    // Retained protection latch, updated only when the window closes.
    always_ff @(posedge clk) begin
        if (rst_n && window_end) begin
            if (pend_q == ACT_ENABLE)       prot_q <= 1'b1;
            else if (pend_q == ACT_DISABLE) prot_q <= 1'b0;
        end
    end

    // Pending action, page write grant and erase pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= ACT_NONE;
            grant_q <= 1'b0;
            erase_q <= 1'b0;
        end else begin
            erase_q <= window_end && (pend_q == ACT_ERASE);
            if (window_end) begin
                pend_q  <= ACT_NONE;
                grant_q <= 1'b0;
            end else if (fire) begin
                if (fire_act == ACT_ERASE) begin
                    pend_q <= prot_q ? ACT_NONE : ACT_ERASE;
                end else begin
                    pend_q  <= fire_act;
                    grant_q <= 1'b1;
                end
            end
        end
    end

    AST_PROT_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> $past(window_end)); // R4
    AST_PROT_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> $past(window_end)); // R5
    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_q |=> !erase_q); // R6
    AST_ERASE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        erase_q |-> !prot_q); // R6
    AST_GRANT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        window_end |=> !grant_q); // R7
endmodule

// File: rtl/swp_seq_decoder.sv
// Software write-protect sequence decoder, top level.
// Watches host byte writes for unlock keys, keeps the retained protection
// state and gates each write towards the page write controller. Only the
// low KEY_W address bits take part in the key compare.
module swp_seq_decoder
    import swp_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int LOAD_TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              write_allow,
    output logic              erase_req,
    output logic              prot_on
);
    logic     window_end;
    logic     fire;
    logic     hold;
    swp_act_e fire_act;
    logic     addr_hi_unused;

    // Address bits above the key field do not take part in decoding (R9).
    assign addr_hi_unused = ^wr_addr[ADDR_W-1:KEY_W];

    swp_load_timer #(.LOAD_TIMEOUT(LOAD_TIMEOUT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .window_end (window_end)
    );

    swp_key_matcher u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .key_addr   (wr_addr[KEY_W-1:0]),
        .wr_data    (wr_data),
        .hold       (hold),
        .window_end (window_end),
        .fire       (fire),
        .fire_act   (fire_act)
    );

    swp_prot_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .fire        (fire),
        .fire_act    (fire_act),
        .window_end  (window_end),
        .hold        (hold),
        .write_allow (write_allow),
        .erase_req   (erase_req),
        .prot_on     (prot_on)
    );

    AST_NO_WRITE_NO_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> !write_allow); // R3
    AST_FIRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (wr_valid && !hold)); // R11
endmodule

// File: tb/sim_swp_seq_decoder.sv
// Bench for swp_seq_decoder. A behavioural model keeps the written keys in
// a queue and compares its prefixes with the three key lists. The outputs
// are compared with the model in every cycle.
module sim_swp_seq_decoder;
    localparam int TO = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        write_allow, erase_req, prot_on;

    always #2 clk = ~clk;

    swp_seq_decoder #(.ADDR_W(17), .LOAD_TIMEOUT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .write_allow(write_allow), .erase_req(erase_req),
        .prot_on(prot_on)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    // Model state
    bit          m_prot = 0;
    bit          m_grant, m_erase, m_active;
    int          m_cnt, m_pend;
    logic [22:0] hist[$];
    logic [22:0] seq_en[6], seq_dis[6], seq_wipe[6];

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog %s: got cycle %0d expected finish earlier", cur_req, cyc);
            summary();
            $finish;
        end
    end

    function automatic int seq_state(input logic [22:0] s[6], input int len);
        if (hist.size() > len) return 0;
        for (int i = 0; i < hist.size(); i++)
            if (hist[i] != s[i]) return 0;
        return (hist.size() == len) ? 2 : 1;
    endfunction

    task automatic model_reset();
        m_grant = 0; m_erase = 0; m_active = 0; m_cnt = 0; m_pend = 0;
        hist.delete();
    endtask

    task automatic model_edge(input bit v, input logic [16:0] a, input logic [7:0] d);
        bit          closes, e_next;
        logic [22:0] key;
        int          re, rd, rw;
        key    = {a[14:0], d};
        closes = m_active && !v && (m_cnt == TO - 1);
        if (v) begin m_active = 1; m_cnt = 0; end
        else if (closes) begin m_active = 0; m_cnt = 0; end
        else if (m_active) m_cnt++;
        e_next = 0;
        if (closes) begin
            if (m_pend == 1) m_prot = 1;
            if (m_pend == 2) m_prot = 0;
            if (m_pend == 3) e_next = 1;
            m_pend = 0; m_grant = 0;
            hist.delete();
        end
        if (v && m_pend == 0) begin
            hist.push_back(key);
            re = seq_state(seq_en, 3);
            rd = seq_state(seq_dis, 6);
            rw = seq_state(seq_wipe, 6);
            if (re == 2) begin m_pend = 1; m_grant = 1; hist.delete(); end
            else if (rd == 2) begin m_pend = 2; m_grant = 1; hist.delete(); end
            else if (rw == 2) begin if (!m_prot) m_pend = 3; hist.delete(); end
            else if (re == 0 && rd == 0 && rw == 0) begin
                hist.delete();
                if (key == seq_en[0]) hist.push_back(key);
            end
        end
        m_erase = e_next;
    endtask

    task automatic compare(input bit v);
        bit exp_allow;
        exp_allow = v && (!m_prot || m_grant);
        n_cmp += 3;
        if (write_allow !== exp_allow) begin
            n_bad++;
            $display("FAIL %s write_allow: got %0b expected %0b", cur_req, write_allow, exp_allow);
        end
        if (prot_on !== m_prot) begin
            n_bad++;
            $display("FAIL %s prot_on: got %0b expected %0b", cur_req, prot_on, m_prot);
        end
        if (erase_req !== m_erase) begin
            n_bad++;
            $display("FAIL %s erase_req: got %0b expected %0b", cur_req, erase_req, m_erase);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then follow the rising edge.
    task automatic cyc_step(input bit v, input logic [16:0] a, input logic [7:0] d);
        wr_valid = v; wr_addr = a; wr_data = d;
        #1;
        compare(v);
        @(posedge clk);
        model_edge(v, a, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        cyc_step(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc_step(1'b0, 17'h0, 8'h00);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic key3(input logic [16:0] a1, input logic [16:0] a2, input logic [7:0] last);
        wr(a1, 8'hAA); wr(a2, 8'h55); wr(a1, last);
    endtask

    task automatic key6(input logic [16:0] a1, input logic [16:0] a2, input logic [7:0] last);
        wr(a1, 8'hAA); wr(a2, 8'h55); wr(a1, 8'h80);
        wr(a1, 8'hAA); wr(a2, 8'h55); wr(a1, last);
    endtask

    initial begin
        seq_en   = '{ {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'hA0}, 23'h0, 23'h0, 23'h0 };
        seq_dis  = '{ {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h80},
                      {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h20} };
        seq_wipe = '{ {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h80},
                      {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h10} };
        rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        #1;
        n_cmp++;
        if (prot_on !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 power-up prot_on: got %0b expected 0", prot_on);
        end
        do_reset();

        cur_req = "R1"; idle(3);

        cur_req = "R3";
        wr(17'h00100, 8'h12); wr(17'h1FFFF, 8'h34); idle(2); wr(17'h05555, 8'h00);
        idle(TO + 2);

        cur_req = "R6"; key6(17'h05555, 17'h02AAA, 8'h10); idle(TO + 3);

        cur_req = "R4";
        key3(17'h05555, 17'h02AAA, 8'hA0);
        wr(17'h00200, 8'h01); wr(17'h00201, 8'h02); wr(17'h00202, 8'h03);
        idle(TO + 3);

        cur_req = "R3"; wr(17'h00300, 8'h5A); idle(1); wr(17'h00301, 8'hA5); idle(TO + 2);

        cur_req = "R6"; key6(17'h05555, 17'h02AAA, 8'h10); idle(TO + 3);

        cur_req = "R7";
        key3(17'h05555, 17'h02AAA, 8'hA0);
        wr(17'h00400, 8'h77); wr(17'h00401, 8'h78);
        idle(TO + 3);

        cur_req = "R2"; do_reset(); idle(3);

        cur_req = "R8";
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h00);
        wr(17'h00500, 8'h11);
        wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        wr(17'h00501, 8'h22);
        idle(TO + 3);

        cur_req = "R11";
        key3(17'h05555, 17'h02AAA, 8'hA0);
        key6(17'h05555, 17'h02AAA, 8'h20);
        idle(TO + 3);

        cur_req = "R10";
        wr(17'h05555, 8'hAA); idle(TO); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        wr(17'h00600, 8'h33);
        idle(TO + 3);

        cur_req = "R9";
        wr(17'h01555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h01555, 8'hA0); wr(17'h00700, 8'h44);
        idle(TO + 3);

        cur_req = "R5"; key6(17'h15555, 17'h12AAA, 8'h20); wr(17'h00800, 8'h55); idle(TO + 3);

        cur_req = "R9"; key6(17'h15555, 17'h0AAAA, 8'h10); idle(TO + 3);

        cur_req = "R3"; wr(17'h00900, 8'h66); idle(4);

        summary();
        $finish;
    end
endmodule